// File: doc/BRIEF.md
# Cardiac Interval Locking Tracker

This block runs on a sampled ECG front end. It takes two threshold flags from comparators outside the block. One flag rises on the tall ventricular (r) deflection. The other rises on the small atrial (p) deflection. From these flags the block reports the beat-to-beat interval as a tick count. The interval is counted first between r events. Once the block has found the p wave, it counts between p events instead. Every measure of time is in units of a sample `tick`. Clock edges on which `tick` is low change nothing.

Each accepted r event opens a prediction window for the next p wave. The window lies between two fractions of the interval currently reported. It opens at three quarters of that interval and closes at seven eighths of it. The window is the exclusive-OR of two one-shot expirations. A p edge inside the window puts the block in lock. After that, p edges restart the counter and load the output latch. A retriggerable lock timer keeps the lock alive while p edges keep landing inside the window. If the timer runs out, or the counter saturates, the block returns to r-to-r measurement.

Top module: `atrial_interval_tracker`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `interval` is 0 and both `locked` and `window` are 0.
- R2: When not locked, each accepted rising edge of `r_flag` loads `interval` with the number of ticks since the previous counter restart. There is one exception: the first such edge after reset, after leaving lock, or after saturation only restarts the counter, and `interval` keeps its value.
- R3: A rising edge of `r_flag` is ignored, and neither restarts the counter nor loads the latch, while fewer than HOLDOFF ticks have passed since the last accepted r edge.
- R4: Let I be the value `interval` shows just before an accepted r edge. After that edge, `window` is high while the number of ticks since the edge lies in [I - floor(I/4), I - floor(I/8)). A p edge arriving that many ticks after the r edge is accepted.
- R5: A rising edge of `p_flag` outside the window changes neither `locked` nor `interval`.
- R6: A p edge inside the window while unlocked sets `locked` and restarts the counter, and `interval` keeps its value.
- R7: While locked, each in-window p edge loads `interval` with the ticks since the previous in-window p edge. Edges of `r_flag` only reopen the window.
- R8: `locked` falls LOCK_TICKS ticks after the last in-window p edge if no further in-window p edge has arrived. The block then measures r-to-r again, and the first r edge only restarts the counter.
- R9: The counter stops at its all-ones value. Reaching that value clears `locked`, and the next r edge only restarts the counter, so no saturated count is ever latched.
- R10: On clock edges where `tick` is low, no counter, timer or flag advances, and `interval` and `locked` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample enable; one tick is the time unit |
| r_flag | input | 1 | Large-deflection threshold flag (level) |
| p_flag | input | 1 | Small-deflection threshold flag (level) |
| interval | output | W | Latched interval in ticks |
| locked | output | 1 | High while measuring p-to-p |
| window | output | 1 | High while a p edge would be accepted |

## Verification
Several kinds of internal fault show up at the ports on the very next tick. A hold-off fault lets a bounce on `r_flag` through. A wrong restart decision on a mode change loads a short or partial count. Either way `interval` takes a value other than the distance between the two chosen events. If the window bounds are off by one, `window` opens or closes one tick away from the predicted edge. A p edge placed near a bound then fails to take lock, or takes it when it should not. Faults in the lock timer or in saturation show up only at expiry. That is up to LOCK_TICKS ticks or a full counter span later. There `locked` falls early or late, or the next r edge loads a stale count.

// File: rtl/ait_pkg.sv
`timescale 1ns/1ps
package ait_pkg;

    // Which event pair feeds the interval counter.
    typedef enum logic {
        MODE_RR = 1'b0,
        MODE_PP = 1'b1
    } trk_mode_e;

    // Counter control decided per tick from the accepted events.
    typedef struct packed {
        logic restart;
        logic capture;
    } ref_ctl_t;

    // Window opens at three quarters of the interval.
    function automatic int unsigned open_offset(input int unsigned iv);
        return iv - (iv >> 2);
    endfunction

    // Window closes at seven eighths of the interval.
    function automatic int unsigned close_offset(input int unsigned iv);
        return iv - (iv >> 3);
    endfunction

endpackage

// File: rtl/ait_edge_det.sv
`timescale 1ns/1ps
module ait_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i] <= 1'b0;
            end else if (tick) begin
                prev_q[i] <= lvl[i];
            end
        end
        assign rise[i] = tick & lvl[i] & ~prev_q[i];
    end

endmodule

// File: rtl/ait_window.sv
`timescale 1ns/1ps
module ait_window
    import ait_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         start,
    input  logic [W-1:0] ivl,
    output logic         win
);

    logic [W-1:0] el_q;
    logic [W-1:0] open_q;
    logic [W-1:0] close_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            el_q    <= '0;
            open_q  <= '0;
            close_q <= '0;
        end else if (tick) begin
            if (start) begin
                el_q    <= W'(1);
                open_q  <= W'(open_offset(32'(ivl)));
                close_q <= W'(close_offset(32'(ivl)));
            end else if (el_q < close_q) begin
                el_q <= el_q + 1'b1;
            end
        end
    end

    // Two one-shot expirations; the window is the span between them.
    assign win = (el_q >= open_q) ^ (el_q >= close_q);

endmodule

// File: rtl/ait_interval.sv
`timescale 1ns/1ps
module ait_interval #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         restart,
    input  logic         capture,
    output logic [W-1:0] ivl,
    output logic         sat
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] ivl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ivl_q <= '0;
        end else if (tick) begin
            if (restart) begin
                cnt_q <= W'(1);
            end else if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (capture) begin
                ivl_q <= cnt_q;
            end
        end
    end

    assign ivl = ivl_q;
    assign sat = tick & (cnt_q == CNT_MAX) & ~restart;

endmodule

// File: rtl/atrial_interval_tracker.sv
`timescale 1ns/1ps
module atrial_interval_tracker
    import ait_pkg::*;
#(
    parameter int W          = 16,
    parameter int HOLDOFF    = 16,
    parameter int LOCK_TICKS = 4096
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         r_flag,
    input  logic         p_flag,
    output logic [W-1:0] interval,
    output logic         locked,
    output logic         window
);

    localparam int HW = $clog2(HOLDOFF + 1);
    localparam int LW = $clog2(LOCK_TICKS + 1);

    logic [1:0]    lvl;
    logic [1:0]    rise;
    logic          r_acc;
    logic          p_acc;
    logic          win;
    logic          sat;
    ref_ctl_t      ctl;
    trk_mode_e     mode_q;
    logic          fresh_q;
    logic [HW-1:0] ho_q;
    logic [LW-1:0] lt_q;

    assign lvl = {p_flag, r_flag};

    ait_edge_det #(.N(2)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .lvl  (lvl),
        .rise (rise)
    );

    assign r_acc = rise[0] & (ho_q == '0);
    assign p_acc = rise[1] & win;

    always_comb begin
        ctl.restart = p_acc | (r_acc & (mode_q == MODE_RR));
        if (mode_q == MODE_PP) begin
            ctl.capture = ~fresh_q & p_acc;
        end else begin
            ctl.capture = ~fresh_q & r_acc & ~p_acc;
        end
    end

    ait_window #(.W(W)) u_window (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .start (r_acc),
        .ivl   (interval),
        .win   (win)
    );

    ait_interval #(.W(W)) u_interval (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (ctl.restart),
        .capture (ctl.capture),
        .ivl     (interval),
        .sat     (sat)
    );

    // Hold-off keeps a bouncing r flag from re-arming the latch.
    always_ff @(posedge clk) begin
        if (rst) begin
            ho_q <= '0;
        end else if (tick) begin
            if (r_acc) begin
                ho_q <= HW'(HOLDOFF);
            end else if (p_acc) begin
                ho_q <= '0;
            end else if (ho_q != '0) begin
                ho_q <= ho_q - 1'b1;
            end
        end
    end

    // Mode, lock timer and the first-event-after-mode-change flag.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RR;
            fresh_q <= 1'b1;
            lt_q    <= '0;
        end else if (tick) begin
            if (p_acc) begin
                mode_q  <= MODE_PP;
                fresh_q <= 1'b0;
                lt_q    <= LW'(LOCK_TICKS);
            end else if (sat || (lt_q == LW'(1))) begin
                mode_q  <= MODE_RR;
                fresh_q <= 1'b1;
                lt_q    <= '0;
            end else begin
                if (lt_q != '0) begin
                    lt_q <= lt_q - 1'b1;
                end
                if (ctl.restart) begin
                    fresh_q <= 1'b0;
                end
            end
        end
    end

    assign locked = (mode_q == MODE_PP);
    assign window = win;

endmodule

// File: rtl/ait_checker.sv
`timescale 1ns/1ps
module ait_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         r_flag,
    input logic         p_flag,
    input logic [W-1:0] interval,
    input logic         locked,
    input logic         window
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (interval == '0 && !locked && !window));

    a_r10_idle_tick_holds: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(interval) && $stable(locked)));

    a_r6_lock_entry_keeps_interval: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $stable(interval));

    a_r5_lock_needs_p_edge: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> ($past(p_flag) && $past(tick)));

    a_r2_latch_needs_event: assert property (@(posedge clk) disable iff (rst)
        !$stable(interval) |-> ($past(tick) && ($past(r_flag) || $past(p_flag))));

endmodule

bind atrial_interval_tracker ait_checker #(.W(W)) u_ait_checker (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .r_flag   (r_flag),
    .p_flag   (p_flag),
    .interval (interval),
    .locked   (locked),
    .window   (window)
);

// File: tb/atrial_interval_tracker_test.sv
`timescale 1ns/1ps
module atrial_interval_tracker_test;

    localparam int W          = 8;
    localparam int HOLDOFF    = 4;
    localparam int LOCK_TICKS = 150;

    typedef struct {
        int    cyc;
        bit    is_win;
        int    iv;
        bit    lk;
        bit    w;
        string req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b1;
    logic         r_flag = 1'b0;
    logic         p_flag = 1'b0;
    logic [W-1:0] interval;
    logic         locked;
    logic         window;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t q[$];

    atrial_interval_tracker #(
        .W(W), .HOLDOFF(HOLDOFF), .LOCK_TICKS(LOCK_TICKS)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .r_flag   (r_flag),
        .p_flag   (p_flag),
        .interval (interval),
        .locked   (locked),
        .window   (window)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Driver side: expectations pushed into the scoreboard queue.
    task automatic exp_iv(input int c, input int iv, input bit lk, input string req);
        exp_t e;
        e.cyc = c; e.is_win = 1'b0; e.iv = iv; e.lk = lk; e.w = 1'b0; e.req = req;
        q.push_back(e);
    endtask

    task automatic exp_win(input int c, input bit w, input string req);
        exp_t e;
        e.cyc = c; e.is_win = 1'b1; e.iv = 0; e.lk = 1'b0; e.w = w; e.req = req;
        q.push_back(e);
    endtask

    // Flag rises at edge e, held for edges e and e+1.
    task automatic fire_r(input int e);
        while (cyc != e - 1) @(negedge clk);
        r_flag = 1'b1;
        while (cyc != e + 1) @(negedge clk);
        r_flag = 1'b0;
    endtask

    task automatic fire_p(input int e);
        while (cyc != e - 1) @(negedge clk);
        p_flag = 1'b1;
        while (cyc != e + 1) @(negedge clk);
        p_flag = 1'b0;
    endtask

    // Monitor: pops expectations due at this cycle and compares.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.cyc != cyc) begin
                errors++;
                $display("FAIL %s missed check at cyc=%0d (now %0d) actual=none expected=due", e.req, e.cyc, cyc);
            end else if (e.is_win) begin
                if (window !== e.w) begin
                    errors++;
                    $display("FAIL %s cyc=%0d window actual=%0b expected=%0b", e.req, cyc, window, e.w);
                end
            end else if (interval !== W'(e.iv) || locked !== e.lk) begin
                errors++;
                $display("FAIL %s cyc=%0d interval/locked actual=%0d/%0b expected=%0d/%0b",
                         e.req, cyc, interval, locked, e.iv, e.lk);
            end
        end
    end

    initial begin
        // Reset state (R1), window checks cover R4 bounds.
        exp_iv (2,    0, 1'b0, "R1");
        exp_win(2,    1'b0, "R1");
        exp_iv (10,   0, 1'b0, "R2");
        exp_iv (110,  110 - 10, 1'b0, "R2");
        exp_iv (200,  100, 1'b0, "R3");
        exp_iv (210,  210 - 110, 1'b0, "R3");
        exp_iv (240,  100, 1'b0, "R5");
        // r at 210 with I=100: open 75, close 88
        exp_win(283,  1'b0, "R4");
        exp_win(284,  1'b1, "R4");
        exp_iv (290,  100, 1'b1, "R6");
        exp_win(296,  1'b1, "R4");
        exp_win(297,  1'b0, "R4");
        exp_iv (310,  100, 1'b1, "R7");
        exp_iv (392,  392 - 290, 1'b1, "R7");
        // r at 410 with I=102: open 77, close 90
        exp_win(485,  1'b0, "R4");
        exp_win(486,  1'b1, "R4");
        exp_iv (490,  490 - 392, 1'b1, "R7");
        exp_win(499,  1'b0, "R4");
        exp_iv (639,  98, 1'b1, "R8");
        exp_iv (640,  98, 1'b0, "R8");
        exp_iv (710,  98, 1'b0, "R8");
        exp_iv (790,  790 - 710, 1'b0, "R8");
        exp_iv (1100, 80, 1'b0, "R9");
        exp_iv (1200, 1200 - 1100, 1'b0, "R9");
        exp_iv (1300, 1300 - 1200 - 20, 1'b0, "R10");

        while (cyc != 3) @(negedge clk);
        rst = 1'b0;

        fire_r(10);
        fire_r(110);
        fire_r(113);   // bounce inside hold-off
        fire_r(210);
        fire_p(240);   // before window
        fire_p(290);   // inside window: lock
        fire_r(310);
        fire_p(392);
        fire_r(410);
        fire_p(490);
        fire_r(510);
        fire_r(610);
        fire_r(710);   // after lock expiry at 640
        fire_r(790);
        fire_r(1100);  // after saturation at 1045
        fire_r(1200);
        while (cyc != 1229) @(negedge clk);
        tick = 1'b0;
        while (cyc != 1249) @(negedge clk);
        tick = 1'b1;
        fire_r(1300);

        while (cyc != 1310) @(negedge clk);
        if (q.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL scoreboard pending actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule